// File: doc/BRIEF.md
# Multi-Mode Built-In Test Register

A register of configurable width that serves as an ordinary pipeline register in functional operation and as a test resource during self-test. A two-bit mode input picks one of four behaviours on each rising clock edge:

- parallel capture of the data inputs;
- serial shifting along a scan path;
- synchronous clearing;
- linear-feedback stepping.

In the stepping mode, a separate select input decides how the data inputs are used. In pattern generation they are ignored and the register produces a maximal-length pseudo-random sequence. In signature compaction they are folded into every stage, so the register compresses a stream of response words into one signature.

The register is placed between blocks of combinational logic. One instance drives test stimulus into a block while the next instance compacts that block's response. The scan path loads seeds and unloads signatures. A scan-source select feeds the first stage from either the external serial input or the last stage of the register. With the last stage as source the register rotates in place.

Top module: `bist_reg`

## Requirements
- R1: An active-low asynchronous reset forces every stage of `q_o` to 0 at once, without waiting for a clock edge.
- R2: With `mode_i` = 2'b11 (both bits set), the next rising edge copies `d_i` into `q_o`.
- R3: With `mode_i` = 2'b00, the next edge shifts the register one place upward: `q_o[k]` takes the old `q_o[k-1]`, and `q_o[0]` takes the serial source.
- R4: In shift mode, the serial source is `scan_in_i` when `loop_sel_i` = 0 and the old `q_o[WIDTH-1]` when `loop_sel_i` = 1.
- R5: With `mode_i` = 2'b10 (bit 1 set, bit 0 clear), the next edge clears every stage to 0.
- R6: With `mode_i` = 2'b01 and `sig_en_i` = 0, the register steps as a linear-feedback shift register and `d_i` has no effect. `q_o[0]` takes the XOR of the old stages selected by `TAP_MASK`, and `q_o[k]` takes the old `q_o[k-1]`. With WIDTH = 3 and TAP_MASK = 3'b110, starting from `q_o` = 1, the values of `q_o` are 1, 2, 5, 3, 7, 6, 4, and then 1 again, so the sequence has period 7.
- R7: In pattern generation (`mode_i` = 2'b01, `sig_en_i` = 0), a register holding all zeros loads the seed `q_o` = 1 on the next edge, so it cannot lock up.
- R8: With `mode_i` = 2'b01 and `sig_en_i` = 1, every stage also XORs in its own data bit: `q_o[0]` takes the feedback XOR `d_i[0]`, and `q_o[k]` takes the old `q_o[k-1]` XOR `d_i[k]`. There is no seeding, so a zero register with zero data stays at zero.
- R9: `scan_out_o` always equals `q_o[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Behaviour select: 00 shift, 01 feedback step, 10 clear, 11 parallel load |
| sig_en_i | input | 1 | In feedback step: 1 compacts `d_i`, 0 generates patterns |
| loop_sel_i | input | 1 | Serial source for shift: 0 `scan_in_i`, 1 last stage |
| scan_in_i | input | 1 | External serial input |
| d_i | input | WIDTH | Parallel data inputs |
| q_o | output | WIDTH | Register stages |
| scan_out_o | output | 1 | Serial output, the last stage |

## Verification
The hardest case to reach from the ports is the all-zero state in pattern mode. The register never enters that state on its own while generating patterns. The bench reaches it by clearing the register and then stepping it, which shows the seed taking effect. The signature step is checked for every pairing of starting state and data word. Each starting state is first placed in the register by a parallel load, so all 64 pairings can be checked in a small three-stage configuration.

// File: rtl/bist_reg_pkg.sv
package bist_reg_pkg;

   typedef enum logic [1:0] {
      MODE_SHIFT = 2'b00,
      MODE_STEP  = 2'b01,
      MODE_CLEAR = 2'b10,
      MODE_LOAD  = 2'b11
   } bist_mode_e;

endpackage

// File: rtl/bist_reg_fb.sv
module bist_reg_fb #(
   parameter int unsigned WIDTH = 8,
   parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
   input  logic [WIDTH-1:0] state_i,
   output logic             fb_o
);
   logic [WIDTH:0] chain;

   assign chain[0] = 1'b0;

   for (genvar t = 0; t < WIDTH; t++) begin : g_tap
      if (TAP_MASK[t]) begin : g_on
         assign chain[t+1] = chain[t] ^ state_i[t];
      end else begin : g_off
         assign chain[t+1] = chain[t];
      end
   end

   assign fb_o = chain[WIDTH];
endmodule

// File: rtl/bist_reg_seed.sv
module bist_reg_seed #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] state_i,
   input  logic             gen_i,
   output logic             kick_o
);
   // A seed is needed only while generating patterns from the all-zero state.
   assign kick_o = gen_i & ~(|state_i);
endmodule

// File: rtl/bist_reg_cell.sv
module bist_reg_cell
   import bist_reg_pkg::*;
(
   input  bist_mode_e mode_i,
   input  logic       sig_en_i,
   input  logic       shift_in_i,
   input  logic       lfsr_in_i,
   input  logic       d_i,
   output logic       next_o
);
   always_comb begin
      unique case (mode_i)
         MODE_LOAD:  next_o = d_i;
         MODE_CLEAR: next_o = 1'b0;
         MODE_SHIFT: next_o = shift_in_i;
         MODE_STEP:  next_o = lfsr_in_i ^ (sig_en_i & d_i);
         default:    next_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/bist_reg.sv
module bist_reg
   import bist_reg_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       mode_i,
   input  logic             sig_en_i,
   input  logic             loop_sel_i,
   input  logic             scan_in_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             scan_out_o
);
   localparam int unsigned MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1};

   if (WIDTH < 2) begin : g_bad_width
      $error("bist_reg: WIDTH must be at least 2");
   end
   if (!TAP_MASK[MSB]) begin : g_bad_taps
      $error("bist_reg: TAP_MASK must include the last stage");
   end

   bist_mode_e       mode;
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] state_d;
   logic             fb;
   logic             kick;
   logic             serial_src;

   assign mode       = bist_mode_e'(mode_i);
   assign serial_src = loop_sel_i ? state_q[MSB] : scan_in_i;

   bist_reg_fb #(
      .WIDTH    (WIDTH),
      .TAP_MASK (TAP_MASK)
   ) i_fb (
      .state_i (state_q),
      .fb_o    (fb)
   );

   bist_reg_seed #(
      .WIDTH (WIDTH)
   ) i_seed (
      .state_i (state_q),
      .gen_i   (!sig_en_i),
      .kick_o  (kick)
   );

   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      logic shift_in;
      logic lfsr_in;
      if (k == 0) begin : g_head
         assign shift_in = serial_src;
         assign lfsr_in  = fb | kick;
      end else begin : g_body
         assign shift_in = state_q[k-1];
         assign lfsr_in  = state_q[k-1];
      end

      bist_reg_cell i_cell (
         .mode_i     (mode),
         .sig_en_i   (sig_en_i),
         .shift_in_i (shift_in),
         .lfsr_in_i  (lfsr_in),
         .d_i        (d_i[k]),
         .next_o     (state_d[k])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= '0;
      end else begin
         state_q <= state_d;
      end
   end

   assign q_o        = state_q;
   assign scan_out_o = state_q[MSB];

   AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b11) |=> (q_o == $past(d_i)));  // R2

   AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b00) |=> (q_o[MSB:1] == $past(q_o[MSB-1:0])));  // R3

   AST_SHIFT_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b00 && loop_sel_i) |=> (q_o[0] == $past(scan_out_o)));  // R4

   AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b10) |=> (q_o == '0));  // R5

   AST_GEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && !sig_en_i && q_o != '0) |=> (q_o != '0));  // R6

   AST_SEED_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && !sig_en_i && q_o == '0) |=> (q_o == SEED));  // R7

   AST_SIG_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && sig_en_i && q_o == '0 && d_i == '0) |=> (q_o == '0));  // R8
endmodule

// File: tb/test_bist_reg.sv
module test_bist_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b11;
   logic       sig_en = 1'b0;
   logic       loop_sel = 1'b0;
   logic       scan_in = 1'b0;
   logic [2:0] d = 3'b000;
   logic [2:0] q;
   logic       scan_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bist_reg #(
      .WIDTH    (3),
      .TAP_MASK (3'b110)
   ) i_bist_reg (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .mode_i     (mode),
      .sig_en_i   (sig_en),
      .loop_sel_i (loop_sel),
      .scan_in_i  (scan_in),
      .d_i        (d),
      .q_o        (q),
      .scan_out_o (scan_out)
   );

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Apply inputs at a falling edge, then wait past one rising edge.
   task automatic step(input logic [1:0] m, input logic s, input logic l,
                       input logic si, input logic [2:0] dv);
      mode = m; sig_en = s; loop_sel = l; scan_in = si; d = dv;
      @(negedge clk);
   endtask

   function automatic logic [2:0] lfsr_next(input logic [2:0] s);
      return {s[1], s[0], s[1] ^ s[2]};
   endfunction

   initial begin
      logic [2:0] cur;
      logic [2:0] seq [7];
      seq = '{3'd1, 3'd2, 3'd5, 3'd3, 3'd7, 3'd6, 3'd4};

      repeat (2) @(negedge clk);
      chk("R1 reset state", q, 3'd0);
      chk("R9 reset scan_out", {2'b0, scan_out}, 3'd0);
      rst_n = 1'b1;

      for (int v = 0; v < 8; v++) begin
         step(2'b11, 1'b0, 1'b0, 1'b0, 3'(v));
         chk("R2 load", q, 3'(v));
         chk("R9 scan_out", {2'b0, scan_out}, {2'b0, q[2]});
      end

      step(2'b11, 1'b0, 1'b0, 1'b0, 3'd6);
      #3 rst_n = 1'b0;
      #1 chk("R1 async reset", q, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;

      step(2'b11, 1'b0, 1'b0, 1'b0, 3'd7);
      step(2'b10, 1'b0, 1'b0, 1'b1, 3'd7);
      chk("R5 clear", q, 3'd0);

      for (int v = 0; v < 8; v++) begin
         for (int si = 0; si < 2; si++) begin
            step(2'b11, 1'b0, 1'b0, 1'b0, 3'(v));
            step(2'b00, 1'b0, 1'b0, 1'(si), 3'd0);
            chk("R3 shift from scan_in", q, {3'(v) << 1} | 3'(si));
         end
         step(2'b11, 1'b0, 1'b0, 1'b0, 3'(v));
         step(2'b00, 1'b0, 1'b1, 1'b0, 3'd5);
         chk("R4 loop shift", q, {3'(v) << 1} | {2'b0, 3'(v) >> 2});
      end

      step(2'b11, 1'b0, 1'b0, 1'b0, 3'd1);
      cur = 3'd1;
      for (int i = 0; i < 7; i++) begin
         chk("R6 sequence", q, seq[i]);
         step(2'b01, 1'b0, 1'b0, 1'b1, 3'(i * 3 + 1));
         cur = lfsr_next(cur);
         chk("R6 model step", q, cur);
      end
      chk("R6 period 7", q, 3'd1);

      step(2'b10, 1'b0, 1'b0, 1'b0, 3'd0);
      step(2'b01, 1'b0, 1'b0, 1'b0, 3'd7);
      chk("R7 seed from zero", q, 3'd1);

      for (int v = 0; v < 8; v++) begin
         for (int dv = 0; dv < 8; dv++) begin
            step(2'b11, 1'b0, 1'b0, 1'b0, 3'(v));
            step(2'b01, 1'b1, 1'b0, 1'b0, 3'(dv));
            chk("R8 signature", q, lfsr_next(3'(v)) ^ 3'(dv));
         end
      end
      step(2'b10, 1'b0, 1'b0, 1'b0, 3'd0);
      step(2'b01, 1'b1, 1'b0, 1'b0, 3'd0);
      chk("R8 zero holds", q, 3'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule